// File: doc/BRIEF.md
# Multi-Channel Phase-Offset PWM Generator

The block drives several pulse-width modulated outputs from one clock. Every channel has its own period and high time, so channels may run at unrelated rates. A common offset counter, separate from every channel, serves as the time base for the start of each channel. A channel stays idle until this counter reaches the channel's own programmed offset. Channel 0 is handled like every other channel, so its offset also delays it.

New period, high-time and offset values are first written into a staging set, one channel at a time. They take effect together at a restart. A soft reset causes a restart at once. A load pulse causes a restart only when every running channel has reached the last cycle of its period, so no running pulse is cut short. A build-time option lets an external sync pulse start the offset counter after a restart. Several generators can then be aligned to a shared event. Software issues a soft reset to arm the generator again before each alignment.

Top module: `pwm_phase_gen`

## Requirements
- R1: A synchronous `rst` makes every `pwm_out` bit low at the next edge. It clears all staged and active settings and halts the offset counter. The outputs stay low until a restart brings in a nonzero period.
- R2: When `cfg_we` is high, the edge stores `cfg_period`, `cfg_width` and `cfg_offset` into the staging set of channel `cfg_ch`. Staged values have no effect on `pwm_out` until the next restart. A write in the same cycle as a restart lands only in the staging set.
- R3: When `soft_rst` is sampled high at edge E, a restart happens at E. Staged values become active, the offset counter returns to zero, every output is low after E, and any pending load is dropped.
- R4: Channel i has a nonzero period and a nonzero width. After a restart at edge E, its output is low up to and including edge E+offset_i+1 and is first high after edge E+offset_i+2. Channel 0 follows the same rule.
- R5: Once started, a channel's output is high for the first min(width, period) cycles of each period and low for the rest. A width at or above the period gives a constant high output. A width of zero gives a constant low output.
- R6: The start time of a channel depends only on its own offset and the restart time, never on another channel's period. A started channel repeats its period until the next restart.
- R7: A channel whose active period is zero is inactive. Its output stays low, and it is ignored when deciding whether a load may complete.
- R8: When `load` is sampled high at edge L, the restart happens at the first edge at or after L at which every started active channel is in the last cycle of its period (count equals period minus one). Channels that have not started count as finished. Until that edge the old settings keep running.
- R9: A load that can never complete stays pending while the outputs keep their old pattern. A `soft_rst` then completes it at once with the newest staged values.
- R10: With parameter `SYNC_EXT` = 0, `ext_sync` has no effect. With `SYNC_EXT` = 1, the offset counter is held at zero after a restart until `ext_sync` is sampled high at edge S. The timing of R4 then applies with S in place of E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Restart now with staged settings |
| load | input | 1 | Request a restart at the next common period end |
| ext_sync | input | 1 | Starts the offset counter when `SYNC_EXT` = 1 |
| cfg_we | input | 1 | Write strobe for the staging set |
| cfg_ch | input | CHW | Channel selected for the write |
| cfg_period | input | CW | Period in cycles, zero disables the channel |
| cfg_width | input | CW | High time in cycles |
| cfg_offset | input | CW | Start delay against the offset counter |
| pwm_out | output | NCH | Registered PWM outputs, one bit per channel |

## Verification
A wrong offset count or start flag shows up as a channel whose first high pulse is early or late against edge E+offset+2. A wrong channel counter shows up within one period as a pulse of the wrong length or a wrong repeat rate. A wrong reload decision shows up as a switch to the new pattern in the wrong cycle. A load that waits forever or completes too soon is caught in the first cycle where the old and new patterns differ. The bench runs a cycle-exact model of the outputs next to the design, so each of these faults is caught in the cycle where it first reaches `pwm_out`.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Offset sequencer: halted after reset, armed waiting for sync, running.
  typedef enum logic [1:0] {
    SEQ_HALT  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_e;

  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  localparam int CHW = pwm_pkg::sel_width(NCH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [CHW-1:0]          ch,
  input  logic [CW-1:0]           period,
  input  logic [CW-1:0]           width,
  input  logic [CW-1:0]           offset,
  input  logic                    apply,
  output logic [NCH-1:0][CW-1:0]  act_period,
  output logic [NCH-1:0][CW-1:0]  act_width,
  output logic [NCH-1:0][CW-1:0]  act_offset
);

  logic [NCH-1:0][CW-1:0] stg_period;
  logic [NCH-1:0][CW-1:0] stg_width;
  logic [NCH-1:0][CW-1:0] stg_offset;

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    logic hit;
    assign hit = we && (ch == CHW'(i));

    // staging registers: written any time, not visible to the channel
    always_ff @(posedge clk) begin
      if (rst) begin
        stg_period[i] <= '0;
        stg_width[i]  <= '0;
        stg_offset[i] <= '0;
      end else if (hit) begin
        stg_period[i] <= period;
        stg_width[i]  <= width;
        stg_offset[i] <= offset;
      end
    end

    // active registers: copied only on a restart (old staged value wins)
    always_ff @(posedge clk) begin
      if (rst) begin
        act_period[i] <= '0;
        act_width[i]  <= '0;
        act_offset[i] <= '0;
      end else if (apply) begin
        act_period[i] <= stg_period[i];
        act_width[i]  <= stg_width[i];
        act_offset[i] <= stg_offset[i];
      end
    end
  end

endmodule

// File: rtl/pwm_offset_seq.sv
module pwm_offset_seq #(
  parameter int CW       = 16,
  parameter bit SYNC_EXT = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          load,
  input  logic          ext_sync,
  input  logic          all_done,
  output logic          restart,
  output logic          ofs_run,
  output logic [CW-1:0] ofs_cnt
);
  import pwm_pkg::*;

  localparam logic [CW-1:0] CNT_MAX = '1;

  seq_state_e state;
  logic       pend;
  logic       sync_go;

  // a soft reset is immediate; a load (new or held) waits for period ends
  assign restart = soft_rst || ((load || pend) && all_done);
  assign ofs_run = (state == SEQ_RUN);

  generate
    if (SYNC_EXT) begin : g_ext
      assign sync_go = ext_sync;
    end else begin : g_int
      assign sync_go = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_HALT;
      ofs_cnt <= '0;
      pend    <= 1'b0;
    end else if (restart) begin
      ofs_cnt <= '0;
      pend    <= 1'b0;
      state   <= SYNC_EXT ? SEQ_ARMED : SEQ_RUN;
    end else begin
      if (load) pend <= 1'b1;
      case (state)
        SEQ_RUN:   if (ofs_cnt != CNT_MAX) ofs_cnt <= ofs_cnt + 1'b1;
        SEQ_ARMED: if (sync_go) state <= SEQ_RUN;
        default:   state <= state;
      endcase
    end
  end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          ofs_run,
  input  logic [CW-1:0] ofs_cnt,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] offset,
  output logic          pwm,
  output logic          started,
  output logic [CW-1:0] cnt,
  output logic          done
);

  logic active;
  logic last;

  assign active = (period != '0);
  assign last   = (cnt == period - 1'b1);
  // an idle or not-yet-started channel never holds back a reload
  assign done   = !started || last;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      started <= 1'b0;
      cnt     <= '0;
      pwm     <= 1'b0;
    end else begin
      pwm <= started && (cnt < width);
      if (!started) begin
        if (active && ofs_run && (ofs_cnt == offset)) begin
          started <= 1'b1;
          cnt     <= '0;
        end
      end else begin
        cnt <= last ? '0 : cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen #(
  parameter int NCH      = 4,
  parameter int CW       = 16,
  parameter bit SYNC_EXT = 1'b0,
  localparam int CHW = pwm_pkg::sel_width(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            soft_rst,
  input  logic            load,
  input  logic            ext_sync,
  input  logic            cfg_we,
  input  logic [CHW-1:0]  cfg_ch,
  input  logic [CW-1:0]   cfg_period,
  input  logic [CW-1:0]   cfg_width,
  input  logic [CW-1:0]   cfg_offset,
  output logic [NCH-1:0]  pwm_out
);

  logic                   restart;
  logic                   ofs_run;
  logic [CW-1:0]          ofs_cnt;
  logic                   all_done;
  logic [NCH-1:0][CW-1:0] act_period;
  logic [NCH-1:0][CW-1:0] act_width;
  logic [NCH-1:0][CW-1:0] act_offset;
  logic [NCH-1:0][CW-1:0] ch_cnt;
  logic [NCH-1:0]         ch_started;
  logic [NCH-1:0]         ch_done;

  assign all_done = &ch_done;

  pwm_shadow_bank #(.NCH(NCH), .CW(CW)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .we         (cfg_we),
    .ch         (cfg_ch),
    .period     (cfg_period),
    .width      (cfg_width),
    .offset     (cfg_offset),
    .apply      (restart),
    .act_period (act_period),
    .act_width  (act_width),
    .act_offset (act_offset)
  );

  pwm_offset_seq #(.CW(CW), .SYNC_EXT(SYNC_EXT)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .load     (load),
    .ext_sync (ext_sync),
    .all_done (all_done),
    .restart  (restart),
    .ofs_run  (ofs_run),
    .ofs_cnt  (ofs_cnt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_channel #(.CW(CW)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .restart (restart),
      .ofs_run (ofs_run),
      .ofs_cnt (ofs_cnt),
      .period  (act_period[i]),
      .width   (act_width[i]),
      .offset  (act_offset[i]),
      .pwm     (pwm_out[i]),
      .started (ch_started[i]),
      .cnt     (ch_cnt[i]),
      .done    (ch_done[i])
    );
  end

endmodule

// File: rtl/pwm_phase_chk.sv
module pwm_phase_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   soft_rst,
  input logic                   restart,
  input logic                   ofs_run,
  input logic [CW-1:0]          ofs_cnt,
  input logic [NCH-1:0][CW-1:0] act_period,
  input logic [NCH-1:0][CW-1:0] act_width,
  input logic [NCH-1:0][CW-1:0] ch_cnt,
  input logic [NCH-1:0]         ch_started,
  input logic [NCH-1:0]         pwm_out
);

  assert_restart_low_R3: assert property (@(posedge clk) disable iff (rst)
    restart |=> (pwm_out == '0));

  assert_offset_zero_R3: assert property (@(posedge clk) disable iff (rst)
    restart |=> (ofs_cnt == '0));

  assert_offset_step_R4: assert property (@(posedge clk) disable iff (rst)
    (ofs_run && !restart && (ofs_cnt != '1)) |=> (ofs_cnt == CW'($past(ofs_cnt) + 1'b1)));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
      (act_period[i] == '0) |=> !pwm_out[i]);

    assert_wait_low_R4: assert property (@(posedge clk) disable iff (rst)
      !ch_started[i] |=> !pwm_out[i]);

    assert_full_high_R5: assert property (@(posedge clk) disable iff (rst)
      (ch_started[i] && !restart && (act_width[i] >= act_period[i])) |=> pwm_out[i]);

    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (rst)
      ch_started[i] |-> (ch_cnt[i] < act_period[i]));

    assert_reload_waits_R8: assert property (@(posedge clk) disable iff (rst)
      (ch_started[i] && (ch_cnt[i] != act_period[i] - 1'b1) && !soft_rst) |-> !restart);
  end

endmodule

bind pwm_phase_gen pwm_phase_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .soft_rst   (soft_rst),
  .restart    (restart),
  .ofs_run    (ofs_run),
  .ofs_cnt    (ofs_cnt),
  .act_period (act_period),
  .act_width  (act_width),
  .ch_cnt     (ch_cnt),
  .ch_started (ch_started),
  .pwm_out    (pwm_out)
);

// File: tb/tb_pwm_phase_gen.sv
`timescale 1ns/1ps
module tb_pwm_phase_gen;
  localparam int NCH = 4;
  localparam int CW  = 16;
  localparam int CHW = 2;

  logic clk = 1'b0, rst = 1'b1, soft_rst = 1'b0, load = 1'b0;
  logic ext_sync = 1'b0, ext_sync2 = 1'b0, cfg_we = 1'b0;
  logic [CHW-1:0] cfg_ch = '0;
  logic [CW-1:0]  cfg_period = '0, cfg_width = '0, cfg_offset = '0;
  logic [NCH-1:0] pwm_out, pwm_out2;

  int n_cmp = 0, n_bad = 0;
  bit done_flag = 1'b0;
  string phase = "R1";
  logic [NCH-1:0] expq[$];

  always #2.5 clk = ~clk;   // 200 MHz

  pwm_phase_gen #(.NCH(NCH), .CW(CW), .SYNC_EXT(1'b0)) dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .load(load), .ext_sync(ext_sync),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_period(cfg_period),
    .cfg_width(cfg_width), .cfg_offset(cfg_offset), .pwm_out(pwm_out));

  pwm_phase_gen #(.NCH(NCH), .CW(CW), .SYNC_EXT(1'b1)) dut_sync (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .load(load), .ext_sync(ext_sync2),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_period(cfg_period),
    .cfg_width(cfg_width), .cfg_offset(cfg_offset), .pwm_out(pwm_out2));

  // ---------------- reference model (from the requirements) ----------------
  int sh_p[NCH], sh_w[NCH], sh_o[NCH];
  int ac_p[NCH], ac_w[NCH], ac_o[NCH];
  int m_edges;       // edges since the last restart
  bit m_pend;

  function automatic logic [NCH-1:0] model_out();
    logic [NCH-1:0] v = '0;
    for (int i = 0; i < NCH; i++)
      if (ac_p[i] != 0 && m_edges >= ac_o[i] + 1)
        v[i] = ((m_edges - 1 - ac_o[i]) % ac_p[i]) < ac_w[i];
    return v;
  endfunction

  function automatic bit model_done();
    for (int i = 0; i < NCH; i++)
      if (ac_p[i] != 0 && m_edges >= ac_o[i] + 1)
        if (((m_edges - 1 - ac_o[i]) % ac_p[i]) != ac_p[i] - 1) return 1'b0;
    return 1'b1;
  endfunction

  // driver side of the scoreboard: one expected vector per edge
  always @(posedge clk) begin : model_push
    logic [NCH-1:0] e;
    bit rs;
    e = '0;
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        sh_p[i] = 0; sh_w[i] = 0; sh_o[i] = 0;
        ac_p[i] = 0; ac_w[i] = 0; ac_o[i] = 0;
      end
      m_edges = 0;
      m_pend  = 1'b0;
    end else begin
      rs = soft_rst || ((load || m_pend) && model_done());
      if (rs) begin
        ac_p = sh_p; ac_w = sh_w; ac_o = sh_o;
        m_edges = 0;
        m_pend  = 1'b0;
      end else begin
        e = model_out();
        m_edges++;
        if (load) m_pend = 1'b1;
      end
      if (cfg_we) begin
        sh_p[cfg_ch] = int'(cfg_period);
        sh_w[cfg_ch] = int'(cfg_width);
        sh_o[cfg_ch] = int'(cfg_offset);
      end
    end
    expq.push_back(e);
  end

  // monitor side: compare away from the active edge
  always @(negedge clk) begin : monitor_pop
    logic [NCH-1:0] e;
    if (expq.size() > 0 && !done_flag) begin
      e = expq.pop_front();
      n_cmp++;
      if (pwm_out !== e) begin
        n_bad++;
        $display("FAIL %s: pwm_out=%b expected %b at %0t", phase, pwm_out, e, $time);
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic check_vec(input string req, input logic [NCH-1:0] act,
                           input logic [NCH-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input int ch, input int p, input int w, input int o);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = CHW'(ch);
    cfg_period = CW'(p); cfg_width = CW'(w); cfg_offset = CW'(o);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_soft();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
  endtask

  task automatic pulse_load();
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic finish_run();
    done_flag = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin : main
    idle(4);
    check_vec("R1 reset outputs", pwm_out, '0);
    check_vec("R1 reset outputs sync build", pwm_out2, '0);
    rst = 1'b0;
    idle(3);

    // R2: staged values alone do nothing
    phase = "R2";
    write_cfg(0, 8, 3, 2);   // offset on channel 0 itself
    write_cfg(1, 4, 6, 6);   // width above period: constant high
    write_cfg(2, 4, 0, 2);   // width zero: constant low
    write_cfg(3, 0, 3, 0);   // period zero: inactive
    idle(12);
    check_vec("R2 staging invisible", pwm_out, '0);

    // R3: immediate restart
    phase = "R3";
    pulse_soft();
    check_vec("R3 low after restart edge", pwm_out, '0);
    phase = "R4 R5 R6 R7";
    idle(60);

    // R2: new staging during a run leaves the pattern alone
    phase = "R2 running";
    write_cfg(0, 10, 4, 0);
    write_cfg(1, 5, 2, 3);
    write_cfg(2, 0, 1, 0);
    write_cfg(3, 3, 1, 7);
    idle(20);

    // R8: reload waits for a common period end
    phase = "R8";
    pulse_load();
    idle(60);

    // R9: this set never reaches a common end, load stays pending
    phase = "R9 pending";
    write_cfg(0, 6, 3, 1);
    write_cfg(1, 6, 1, 4);
    write_cfg(2, 2, 1, 0);
    write_cfg(3, 0, 2, 0);
    pulse_load();
    idle(40);
    phase = "R9 soft completes";
    pulse_soft();
    idle(30);

    // R10: external sync ignored in the internal build
    phase = "R10 ignored";
    @(negedge clk); ext_sync = 1'b1;
    @(negedge clk); ext_sync = 1'b0;
    idle(20);

    // R10: external sync build waits for the pulse
    phase = "R10";
    pulse_soft();
    idle(20);
    check_vec("R10 held before sync", pwm_out2, '0);
    @(negedge clk); ext_sync2 = 1'b1;
    @(negedge clk); ext_sync2 = 1'b0;   // now just after edge S
    idle(1);
    check_vec("R10 S+1 all low", pwm_out2, 4'b0000);
    idle(1);
    check_vec("R10 S+2 offset-0 channel high", pwm_out2, 4'b0100);
    idle(1);
    check_vec("R10 S+3 channel 0 high", pwm_out2, 4'b0001);
    idle(3);
    finish_run();
  end

endmodule